// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a 16-bit word that tells software why the chip last came out of reset and whether it last entered a low-power state. Hardware event strobes set the flags. Each strobe is a one-cycle pulse on `clk`. Every flag has its own set source and its own clear sources.

A power-on or brown-out event wipes the history flags. Every other kind of reset leaves them alone, so after a watchdog reset or an external reset the flags that were already recorded are still there. The power-on and brown-out flags are cleared only by software. Software reads `flags_q` and can overwrite every implemented flag through a plain write strobe. The normal pattern is to read the cause and then write zero.

There is no handshake on either side. A strobe or a write that is present on a rising edge of `clk` takes effect on that edge, and `flags_q` shows the result straight after it. `rst_n` is the supply-level reset of the block's own storage. It is not one of the resets the block records. Making resets is not part of this block.

Top module: `reset_cause_reg`

## Requirements
- R1: While `rst_n` is low, `flags_q` reads 0x0003, which is the power-on state: bit 1 and bit 0 are set and every other bit is clear.
- R2: A strobe sets its flag on the next rising edge. The mapping is: `ev_trap` sets bit 15; `ev_illegal` (illegal opcode, uninitialised-register access or security violation) sets bit 14; `ev_cfg` sets bit 9; `ev_extpin` sets bit 7; `ev_swrst` sets bit 6; `ev_wdt_to` sets bit 4; `ev_sleep` sets bit 3; `ev_idle` sets bit 2.
- R3: `ev_por` or `ev_bor` clears bits 15, 14, 9, 7, 6, 4, 3 and 2.
- R4: `ev_por` sets bit 1 and bit 0. `ev_bor` sets bit 1 and leaves bit 0 unchanged.
- R5: No strobe clears bit 1 or bit 0. Only a software write clears them.
- R6: `ev_wdt_clr` (watchdog clear instruction) or `ev_pwrsav` (any power-save instruction) clears bit 4.
- R7: When `wr_en` is high, every implemented bit takes the value of the matching bit of `wr_data`.
- R8: A set strobe for a bit wins over a clear strobe and over a software write to that bit in the same cycle.
- R9: A software write wins over a hardware clear strobe for the same bit in the same cycle.
- R10: Bits 13, 12, 11, 10, 8 and 5 always read 0 and ignore writes.
- R11: With no strobe and no write, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low supply-level reset of the flag storage |
| ev_por | input | 1 | Power-on event strobe |
| ev_bor | input | 1 | Brown-out event strobe |
| ev_extpin | input | 1 | External reset pin event strobe |
| ev_swrst | input | 1 | Reset instruction strobe |
| ev_wdt_to | input | 1 | Watchdog timeout strobe |
| ev_trap | input | 1 | Trap conflict strobe |
| ev_illegal | input | 1 | Illegal opcode, uninitialised-register access or security violation strobe |
| ev_cfg | input | 1 | Configuration mismatch strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_idle | input | 1 | Idle entry strobe |
| ev_wdt_clr | input | 1 | Watchdog clear instruction strobe |
| ev_pwrsav | input | 1 | Power-save instruction strobe |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write value |
| flags_q | output | 16 | Flag register value |

## Verification
Every result is due exactly one edge after its stimulus, because there is a single register stage between the strobes and `flags_q`. The bench drives the strobes and writes on the falling edge and updates its behavioural model just after the rising edge. It compares `flags_q` on the following falling edge, so each comparison sees the update of exactly one cycle. Directed steps cover each priority and clear rule on its own. A long random mix then compares the model and the design on every cycle, including cycles where set, clear and write collide.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int FLAG_W = 16;

  localparam int B_TRAP  = 15;
  localparam int B_BADOP = 14;
  localparam int B_CFG   = 9;
  localparam int B_PIN   = 7;
  localparam int B_SWRST = 6;
  localparam int B_WDOG  = 4;
  localparam int B_SLEEP = 3;
  localparam int B_IDLE  = 2;
  localparam int B_BROWN = 1;
  localparam int B_POWER = 0;

  localparam logic [FLAG_W-1:0] SUPPLY_MASK =
    (FLAG_W'(1) << B_BROWN) | (FLAG_W'(1) << B_POWER);

  localparam logic [FLAG_W-1:0] HIST_MASK =
    (FLAG_W'(1) << B_TRAP) | (FLAG_W'(1) << B_BADOP) | (FLAG_W'(1) << B_CFG) |
    (FLAG_W'(1) << B_PIN)  | (FLAG_W'(1) << B_SWRST) | (FLAG_W'(1) << B_WDOG) |
    (FLAG_W'(1) << B_SLEEP) | (FLAG_W'(1) << B_IDLE);

  localparam logic [FLAG_W-1:0] IMPL_MASK = HIST_MASK | SUPPLY_MASK;
  localparam logic [FLAG_W-1:0] RESET_VAL = SUPPLY_MASK;

  typedef struct packed {
    logic power_on;
    logic brown_out;
    logic pin_rst;
    logic sw_rst;
    logic wdog_to;
    logic trap_clash;
    logic bad_op;
    logic cfg_bad;
    logic sleep_go;
    logic idle_go;
    logic wdog_kick;
    logic psave;
  } evt_t;
endpackage

// File: rtl/rcause_event_map.sv
module rcause_event_map
  import rcause_pkg::*;
(
  input  evt_t              ev,
  output logic [FLAG_W-1:0] set_v,
  output logic [FLAG_W-1:0] clr_v
);
  logic supply_evt;
  assign supply_evt = ev.power_on | ev.brown_out;

  always_comb begin
    set_v          = '0;
    set_v[B_TRAP]  = ev.trap_clash;
    set_v[B_BADOP] = ev.bad_op;
    set_v[B_CFG]   = ev.cfg_bad;
    set_v[B_PIN]   = ev.pin_rst;
    set_v[B_SWRST] = ev.sw_rst;
    set_v[B_WDOG]  = ev.wdog_to;
    set_v[B_SLEEP] = ev.sleep_go;
    set_v[B_IDLE]  = ev.idle_go;
    set_v[B_BROWN] = supply_evt;
    set_v[B_POWER] = ev.power_on;
  end

  always_comb begin
    clr_v = '0;
    for (int i = 0; i < FLAG_W; i++) begin
      if (HIST_MASK[i]) clr_v[i] = supply_evt;
    end
    clr_v[B_WDOG] = supply_evt | ev.wdog_kick | ev.psave;
  end
endmodule

// File: rtl/rcause_flag_cell.sv
module rcause_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_i,
  input  logic wd_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (set_i) q <= 1'b1;
    else if (wr_i)  q <= wd_i;
    else if (clr_i) q <= 1'b0;
  end

  // R8: a set strobe wins over both clear and write
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
  // R9: a write wins over a hardware clear
  a_r9_write_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !set_i) |=> (q == $past(wd_i)));
  // R3: a lone clear strobe empties the flag
  a_r3_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !wr_i) |=> !q);
  // R11: the flag holds when nothing touches it
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i && !wr_i) |=> (q == $past(q)));
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcause_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_por,
  input  logic              ev_bor,
  input  logic              ev_extpin,
  input  logic              ev_swrst,
  input  logic              ev_wdt_to,
  input  logic              ev_trap,
  input  logic              ev_illegal,
  input  logic              ev_cfg,
  input  logic              ev_sleep,
  input  logic              ev_idle,
  input  logic              ev_wdt_clr,
  input  logic              ev_pwrsav,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags_q
);
  evt_t              ev;
  logic [FLAG_W-1:0] set_v;
  logic [FLAG_W-1:0] clr_v;
  logic              unused_bits;

  always_comb begin
    ev.power_on   = ev_por;
    ev.brown_out  = ev_bor;
    ev.pin_rst    = ev_extpin;
    ev.sw_rst     = ev_swrst;
    ev.wdog_to    = ev_wdt_to;
    ev.trap_clash = ev_trap;
    ev.bad_op     = ev_illegal;
    ev.cfg_bad    = ev_cfg;
    ev.sleep_go   = ev_sleep;
    ev.idle_go    = ev_idle;
    ev.wdog_kick  = ev_wdt_clr;
    ev.psave      = ev_pwrsav;
  end

  rcause_event_map u_map (
    .ev    (ev),
    .set_v (set_v),
    .clr_v (clr_v)
  );

  for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
    if (IMPL_MASK[g]) begin : g_flag
      rcause_flag_cell #(.RST_VAL(RESET_VAL[g])) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v[g]),
        .clr_i (clr_v[g]),
        .wr_i  (wr_en),
        .wd_i  (wr_data[g]),
        .q     (flags_q[g])
      );
    end else begin : g_tie
      assign flags_q[g] = 1'b0;
    end
  end

  assign unused_bits = ^{set_v & ~IMPL_MASK, clr_v & ~IMPL_MASK, wr_data & ~IMPL_MASK};

  // R10: unassigned positions stay zero
  a_r10_unassigned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~IMPL_MASK) == '0);
  // R6: a watchdog clear or power-save strobe clears the watchdog flag
  a_r6_wdog_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_wdt_clr || ev_pwrsav) && !ev_wdt_to && !wr_en) |=> !flags_q[B_WDOG]);
  // R4: brown-out alone sets bit 1 and leaves bit 0
  a_r4_brownout_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bor && !ev_por && !wr_en) |=> (flags_q[B_BROWN] && flags_q[B_POWER] == $past(flags_q[B_POWER])));
  // R5: without a write, the supply flags never drop
  a_r5_supply_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((flags_q & SUPPLY_MASK) & $past(flags_q & SUPPLY_MASK)) == $past(flags_q & SUPPLY_MASK));
  // R3: power-on or brown-out with no write and no set leaves no history flag
  a_r3_supply_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_por || ev_bor) && !wr_en && !ev_trap && !ev_illegal && !ev_cfg && !ev_extpin
      && !ev_swrst && !ev_wdt_to && !ev_sleep && !ev_idle) |=> ((flags_q & HIST_MASK) == '0));
endmodule

// File: tb/sim_reset_cause_reg.sv
module sim_reset_cause_reg;
  localparam int E_POR = 0, E_BOR = 1, E_PIN = 2, E_SWR = 3, E_WTO = 4, E_TRAP = 5,
                 E_ILL = 6, E_CFG = 7, E_SLP = 8, E_IDL = 9, E_WCLR = 10, E_PSV = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ev = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] flags_q;
  logic [15:0] model;
  int          n_run = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  reset_cause_reg u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_por(ev[E_POR]), .ev_bor(ev[E_BOR]), .ev_extpin(ev[E_PIN]), .ev_swrst(ev[E_SWR]),
    .ev_wdt_to(ev[E_WTO]), .ev_trap(ev[E_TRAP]), .ev_illegal(ev[E_ILL]), .ev_cfg(ev[E_CFG]),
    .ev_sleep(ev[E_SLP]), .ev_idle(ev[E_IDL]), .ev_wdt_clr(ev[E_WCLR]), .ev_pwrsav(ev[E_PSV]),
    .wr_en(wr_en), .wr_data(wr_data), .flags_q(flags_q)
  );

  function automatic logic [15:0] ref_next(logic [15:0] cur, logic [11:0] e,
                                           logic we, logic [15:0] wd);
    logic [15:0] r;
    r = cur;
    if (we) r = wd & 16'hC2DF;
    else begin
      if (e[E_POR] || e[E_BOR]) r = r & 16'h0003;
      if (e[E_WCLR] || e[E_PSV]) r[4] = 1'b0;
    end
    if (e[E_TRAP]) r[15] = 1'b1;
    if (e[E_ILL])  r[14] = 1'b1;
    if (e[E_CFG])  r[9]  = 1'b1;
    if (e[E_PIN])  r[7]  = 1'b1;
    if (e[E_SWR])  r[6]  = 1'b1;
    if (e[E_WTO])  r[4]  = 1'b1;
    if (e[E_SLP])  r[3]  = 1'b1;
    if (e[E_IDL])  r[2]  = 1'b1;
    if (e[E_POR] || e[E_BOR]) r[1] = 1'b1;
    if (e[E_POR])  r[0]  = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag);
    n_run++;
    if (flags_q !== model) begin
      n_fail++;
      $display("FAIL %s: flags_q=%h expected=%h", tag, flags_q, model);
    end
  endtask

  task automatic step(input logic [11:0] e, input logic we, input logic [15:0] wd,
                      input string tag);
    ev = e; wr_en = we; wr_data = wd;
    @(posedge clk);
    #1 model = ref_next(model, e, we, wd);
    @(negedge clk);
    ev = '0; wr_en = 1'b0; wr_data = '0;
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected=completion", cyc);
      finish_run();
    end
  end

  initial begin
    model = 16'h0003;
    repeat (3) @(negedge clk);
    check("R1 reset value");
    rst_n = 1'b1;
    step('0, 1'b0, '0, "R11 hold after reset");
    step('0, 1'b1, 16'h0000, "R7 write zero");
    for (int k = E_PIN; k <= E_IDL; k++) step(12'(1) << k, 1'b0, '0, "R2 set strobe");
    step('0, 1'b1, 16'hFFFF, "R10 write all ones");
    step(12'(1) << E_BOR, 1'b0, '0, "R3 brown-out wipe");
    step('0, 1'b1, 16'h0000, "R7 software clear");
    step(12'(1) << E_BOR, 1'b0, '0, "R4 brown-out keeps bit 0");
    step(12'(1) << E_POR, 1'b0, '0, "R4 power-on sets both");
    step((12'(1) << E_TRAP) | (12'(1) << E_PIN) | (12'(1) << E_SLP), 1'b0, '0,
         "R5 other strobes keep supply flags");
    step(12'(1) << E_WTO, 1'b0, '0, "R2 watchdog timeout");
    step(12'(1) << E_WCLR, 1'b0, '0, "R6 watchdog clear");
    step(12'(1) << E_WTO, 1'b0, '0, "R2 watchdog timeout again");
    step(12'(1) << E_PSV, 1'b0, '0, "R6 power-save clears");
    step((12'(1) << E_WTO) | (12'(1) << E_WCLR), 1'b0, '0, "R8 set beats clear");
    step(12'(1) << E_TRAP, 1'b1, 16'h0000, "R8 set beats write");
    step(12'(1) << E_PSV, 1'b1, 16'h0010, "R9 write beats clear");
    step(12'(1) << E_POR, 1'b1, 16'h0000, "R8 power-on beats write");
    step('0, 1'b0, '0, "R11 idle hold");
    for (int k = 0; k < 600; k++) begin
      logic [11:0] e;
      for (int b = 0; b < 12; b++) e[b] = (($urandom % 8) == 0);
      step(e, (($urandom % 6) == 0), 16'($urandom), "R11 random mix");
    end
    finish_run();
  end
endmodule